// File: doc/BRIEF.md
# Two-Lane Training-Pattern Word Aligner

This block sits behind two deserializers that each deliver one parallel word per cycle: a data lane and an auxiliary control lane. Each deserializer divides its own clock, and the two dividers can come up in different phases. As a result, the two lanes can frame the same serial stream at different bit positions, and this differs from one power-up or acquisition to the next. While the sender repeats a training pattern on both lanes, the aligner compares the two words every cycle. It pulses the bit-slip input of the auxiliary deserializer one bit at a time until both lanes present the same pattern word in the same cycle. After a run of matching words it reports lock.

The two lanes stream into the block all the time. Capture into the downstream buffers is opened by one start request from another clock domain. The request is brought into the capture clock through a two-flop synchronizer and an edge detector, and it raises the write enables of both lanes in the same cycle. Writing needs lock and a start edge since the last realign. A realign input drops lock and both write enables and starts a new search.

The training pattern alternates a configurable word with its bitwise complement. With this alternation a framing error of one whole word shows up as a mismatch. Any framing error that is not a whole number of words shows up as a word that is neither value.

Top module: `lane_pair_aligner`

## Requirements
- R1: While reset is low, `locked`, `alignErr`, `slipAux`, `dataWe` and `auxWe` are all 0.
- R2: A compare counts as a match only when the registered data word equals the registered auxiliary word and that word is either PATTERN (default 0xA5) or its complement (0x5A). Two equal lanes carrying any other value never lead to lock.
- R3: `slipAux` is a single-cycle pulse. After it, no further compare and no further slip happens for SETTLE cycles (default 4). The number of slips issued before lock equals the bit offset by which the auxiliary lane trails the data lane (0 to 15 bits for the default 8-bit word).
- R4: `locked` rises only after LOCK_CNT (default 8) consecutive matching compares, and it then holds until a realign.
- R5: If the search has issued 3×WORD_W slips (24 by default) and the next compare still fails, `alignErr` goes to 1 and `locked` stays 0. No further slips are issued until a realign.
- R6: A rising edge on `startReq` makes `dataWe` and `auxWe` go to 1 on the fourth rising clock edge after the request rises, provided the block is already locked. The two enables are always equal, and neither is ever 1 in a cycle that follows a cycle without lock.
- R7: `dataOut` and `auxOut` carry each lane's input word delayed by two clock edges. While the enables are 1, both outputs carry words from the same stream index.
- R8: When `realign` is 1 at a clock edge, `locked`, `alignErr`, `dataWe` and `auxWe` are 0 after that edge, and a fresh search begins with the slip budget reset.
- R9: A start edge that arrives before lock is remembered. The write enables then rise on the first edge after lock is reached, and stay 0 until then. A realign discards a remembered start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Capture clock shared by both lane words |
| rstN | input | 1 | Asynchronous active-low reset |
| dataIn | input | WORD_W | Parallel word from the data-lane deserializer |
| auxIn | input | WORD_W | Parallel word from the auxiliary-lane deserializer |
| startReq | input | 1 | Capture start level from another clock domain |
| realign | input | 1 | Synchronous request to drop lock and search again |
| slipAux | output | 1 | One-cycle bit-slip pulse to the auxiliary deserializer |
| locked | output | 1 | Both lanes framed identically |
| alignErr | output | 1 | Slip budget used up without a match |
| dataOut | output | WORD_W | Data-lane word toward its output buffer |
| auxOut | output | WORD_W | Auxiliary-lane word toward its output buffer |
| dataWe | output | 1 | Write enable for the data-lane buffer |
| auxWe | output | 1 | Write enable for the auxiliary-lane buffer |

## Verification
The assertions assume that a slip pulse moves the auxiliary framing by exactly one bit within the settle window. They also assume that `startReq` is a level that stays high for at least three capture cycles, and that `realign` is only pulsed between trainings. The lane model in the bench applies each slip at the falling edge after it sees it. The bench holds the start level for many cycles and keeps the auxiliary offset within one pattern period (16 bits) behind the data lane. Within that range the first true match is the correct word framing, and the sweep walks every offset in it.

// File: rtl/aligner_pkg.sv
package aligner_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEARCH,
    ST_SLIP_WAIT,
    ST_VERIFY,
    ST_LOCKED
  } alignState_t;

  // strobes from the sequencing control into the lane datapath
  typedef struct packed {
    logic lockHold;  // locked and not being dropped this cycle
    logic dropRun;   // forget any remembered start request
  } ctrlStrobe_t;

endpackage

// File: rtl/aligner_datapath.sv
module aligner_datapath
  import aligner_pkg::*;
#(
  parameter int WORD_W = 8,
  parameter logic [WORD_W-1:0] PATTERN = 8'hA5,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [WORD_W-1:0] dataIn,
  input  logic [WORD_W-1:0] auxIn,
  input  logic              startReq,
  input  ctrlStrobe_t       strobe,
  output logic              wordMatch,
  output logic [WORD_W-1:0] dataOut,
  output logic [WORD_W-1:0] auxOut,
  output logic              dataWe,
  output logic              auxWe
);

  localparam int LANES = 2;
  localparam logic [WORD_W-1:0] PAT_ALT = ~PATTERN;
  localparam int HIST = SYNC_STAGES + 1;

  logic [WORD_W-1:0] laneIn  [LANES];
  logic [WORD_W-1:0] laneQ   [LANES];
  logic [WORD_W-1:0] laneOut [LANES];
  logic              laneWe  [LANES];

  logic [HIST-1:0] syncQ;
  logic            startEdge;
  logic            runFlag;
  logic            writeGate;

  assign laneIn[0] = dataIn;
  assign laneIn[1] = auxIn;

  // lane input and output registers, one set per lane
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int g = 0; g < LANES; g++) begin
        laneQ[g]   <= '0;
        laneOut[g] <= '0;
        laneWe[g]  <= 1'b0;
      end
    end else begin
      for (int g = 0; g < LANES; g++) begin
        laneQ[g]   <= laneIn[g];
        laneOut[g] <= laneQ[g];
        laneWe[g]  <= writeGate;
      end
    end
  end

  // training compare on the registered words
  assign wordMatch = (laneQ[0] == laneQ[1]) &&
                     ((laneQ[0] == PATTERN) || (laneQ[0] == PAT_ALT));

  // start request: synchronizer chain plus one history flop for the edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= '0;
    else       syncQ <= {syncQ[HIST-2:0], startReq};
  end

  assign startEdge = syncQ[HIST-2] & ~syncQ[HIST-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             runFlag <= 1'b0;
    else if (strobe.dropRun) runFlag <= 1'b0;
    else if (startEdge)    runFlag <= 1'b1;
  end

  assign writeGate = runFlag & strobe.lockHold;

  assign dataOut = laneOut[0];
  assign auxOut  = laneOut[1];
  assign dataWe  = laneWe[0];
  assign auxWe   = laneWe[1];

endmodule

// File: rtl/aligner_control.sv
module aligner_control
  import aligner_pkg::*;
#(
  parameter int LOCK_CNT = 8,
  parameter int SETTLE   = 4,
  parameter int MAX_SLIP = 24
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        realign,
  input  logic        wordMatch,
  output logic        slipAux,
  output logic        locked,
  output logic        alignErr,
  output ctrlStrobe_t strobe
);

  localparam int SLIP_W  = $clog2(MAX_SLIP + 1);
  localparam int MATCH_W = $clog2(LOCK_CNT + 1);
  localparam int WAIT_W  = $clog2(SETTLE + 1);
  localparam logic [SLIP_W-1:0]  SLIP_LIMIT = SLIP_W'(MAX_SLIP);
  localparam logic [MATCH_W-1:0] LOCK_LAST  = MATCH_W'(LOCK_CNT - 1);
  localparam logic [WAIT_W-1:0]  WAIT_INIT  = WAIT_W'(SETTLE);

  alignState_t       state;
  logic [SLIP_W-1:0] slipCnt;
  logic [MATCH_W-1:0] matchCnt;
  logic [WAIT_W-1:0] waitCnt;
  logic              slipQ;
  logic              errQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      slipCnt  <= '0;
      matchCnt <= '0;
      waitCnt  <= '0;
      slipQ    <= 1'b0;
      errQ     <= 1'b0;
    end else begin
      slipQ <= 1'b0;
      if (realign) begin
        state    <= ST_SEARCH;
        slipCnt  <= '0;
        matchCnt <= '0;
        errQ     <= 1'b0;
      end else begin
        unique case (state)
          ST_IDLE: begin
            if (!errQ) state <= ST_SEARCH;
          end
          ST_SEARCH: begin
            if (wordMatch) begin
              if (LOCK_CNT == 1) begin
                state <= ST_LOCKED;
              end else begin
                matchCnt <= MATCH_W'(1);
                state    <= ST_VERIFY;
              end
            end else if (slipCnt == SLIP_LIMIT) begin
              errQ  <= 1'b1;
              state <= ST_IDLE;
            end else begin
              slipQ   <= 1'b1;
              slipCnt <= slipCnt + 1'b1;
              waitCnt <= WAIT_INIT;
              state   <= ST_SLIP_WAIT;
            end
          end
          ST_SLIP_WAIT: begin
            if (waitCnt <= WAIT_W'(1)) state <= ST_SEARCH;
            else                       waitCnt <= waitCnt - 1'b1;
          end
          ST_VERIFY: begin
            if (wordMatch) begin
              if (matchCnt == LOCK_LAST) state <= ST_LOCKED;
              else                       matchCnt <= matchCnt + 1'b1;
            end else begin
              matchCnt <= '0;
              state    <= ST_SEARCH;
            end
          end
          ST_LOCKED: begin
            state <= ST_LOCKED;
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  assign slipAux         = slipQ;
  assign locked          = (state == ST_LOCKED);
  assign alignErr        = errQ;
  assign strobe.lockHold = locked & ~realign;
  assign strobe.dropRun  = realign;

endmodule

// File: rtl/lane_pair_aligner.sv
module lane_pair_aligner
  import aligner_pkg::*;
#(
  parameter int WORD_W = 8,
  parameter logic [WORD_W-1:0] PATTERN = 8'hA5,
  parameter int LOCK_CNT = 8,
  parameter int SETTLE   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [WORD_W-1:0] dataIn,
  input  logic [WORD_W-1:0] auxIn,
  input  logic              startReq,
  input  logic              realign,
  output logic              slipAux,
  output logic              locked,
  output logic              alignErr,
  output logic [WORD_W-1:0] dataOut,
  output logic [WORD_W-1:0] auxOut,
  output logic              dataWe,
  output logic              auxWe
);

  localparam int MAX_SLIP = 3 * WORD_W;

  ctrlStrobe_t strobe;
  logic        wordMatch;

  aligner_control #(
    .LOCK_CNT (LOCK_CNT),
    .SETTLE   (SETTLE),
    .MAX_SLIP (MAX_SLIP)
  ) ctrlI (
    .clk       (clk),
    .rstN      (rstN),
    .realign   (realign),
    .wordMatch (wordMatch),
    .slipAux   (slipAux),
    .locked    (locked),
    .alignErr  (alignErr),
    .strobe    (strobe)
  );

  aligner_datapath #(
    .WORD_W      (WORD_W),
    .PATTERN     (PATTERN),
    .SYNC_STAGES (2)
  ) dpI (
    .clk       (clk),
    .rstN      (rstN),
    .dataIn    (dataIn),
    .auxIn     (auxIn),
    .startReq  (startReq),
    .strobe    (strobe),
    .wordMatch (wordMatch),
    .dataOut   (dataOut),
    .auxOut    (auxOut),
    .dataWe    (dataWe),
    .auxWe     (auxWe)
  );

endmodule

// File: rtl/lane_pair_aligner_chk.sv
module lane_pair_aligner_chk #(
  parameter int WORD_W = 8,
  parameter logic [WORD_W-1:0] PATTERN = 8'hA5,
  parameter int LOCK_CNT = 8,
  parameter int SETTLE   = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic [WORD_W-1:0] dataIn,
  input logic [WORD_W-1:0] auxIn,
  input logic              realign,
  input logic              slipAux,
  input logic              locked,
  input logic              alignErr,
  input logic [WORD_W-1:0] dataOut,
  input logic [WORD_W-1:0] auxOut,
  input logic              dataWe,
  input logic              auxWe
);

  localparam int MAX_SLIP = 3 * WORD_W;
  localparam int RUN_W  = $clog2(LOCK_CNT + 1);
  localparam int GAP_W  = $clog2(SETTLE + 1);
  localparam int BUD_W  = $clog2(MAX_SLIP + 1);

  logic [RUN_W-1:0] runCnt;
  logic [GAP_W-1:0] gapCnt;
  logic [BUD_W-1:0] budCnt;
  logic             inMatch;

  assign inMatch = (dataIn == auxIn) && ((dataIn == PATTERN) || (dataIn == ~PATTERN));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runCnt <= '0;
      gapCnt <= GAP_W'(SETTLE);
      budCnt <= '0;
    end else begin
      if (!inMatch)                     runCnt <= '0;
      else if (runCnt != RUN_W'(LOCK_CNT)) runCnt <= runCnt + 1'b1;
      if (slipAux)                      gapCnt <= '0;
      else if (gapCnt != GAP_W'(SETTLE)) gapCnt <= gapCnt + 1'b1;
      if (realign)                      budCnt <= '0;
      else if (slipAux)                 budCnt <= budCnt + 1'b1;
    end
  end

  AST_SLIP_SINGLE: assert property (@(posedge clk) disable iff (!rstN) slipAux |=> !slipAux); // R3
  AST_SLIP_SPACING: assert property (@(posedge clk) disable iff (!rstN) slipAux |-> gapCnt >= GAP_W'(SETTLE)); // R3
  AST_LOCK_AFTER_RUN: assert property (@(posedge clk) disable iff (!rstN) $rose(locked) |-> $past(runCnt) >= RUN_W'(LOCK_CNT)); // R4
  AST_SLIP_BUDGET: assert property (@(posedge clk) disable iff (!rstN) slipAux |-> budCnt < BUD_W'(MAX_SLIP)); // R5
  AST_ERR_NO_LOCK: assert property (@(posedge clk) disable iff (!rstN) alignErr |-> !locked); // R5
  AST_WE_NEEDS_LOCK: assert property (@(posedge clk) disable iff (!rstN) dataWe |-> $past(locked)); // R6
  AST_LANES_TOGETHER: assert property (@(posedge clk) disable iff (!rstN) dataWe == auxWe); // R6
  AST_OUT_DELAY: assert property (@(posedge clk) disable iff (!rstN) dataWe |-> (dataOut == $past(dataIn, 2)) && (auxOut == $past(auxIn, 2))); // R7
  AST_REALIGN_DROPS: assert property (@(posedge clk) disable iff (!rstN) realign |=> !locked && !dataWe && !alignErr); // R8

endmodule

bind lane_pair_aligner lane_pair_aligner_chk #(
  .WORD_W   (WORD_W),
  .PATTERN  (PATTERN),
  .LOCK_CNT (LOCK_CNT),
  .SETTLE   (SETTLE)
) chkI (
  .clk      (clk),
  .rstN     (rstN),
  .dataIn   (dataIn),
  .auxIn    (auxIn),
  .realign  (realign),
  .slipAux  (slipAux),
  .locked   (locked),
  .alignErr (alignErr),
  .dataOut  (dataOut),
  .auxOut   (auxOut),
  .dataWe   (dataWe),
  .auxWe    (auxWe)
);

// File: tb/lane_pair_aligner_test.sv
module lane_pair_aligner_test;

  localparam int W = 8;
  localparam logic [W-1:0] PAT = 8'hA5;
  localparam int DOFF = 16;
  localparam int BUDGET = 3 * W;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [W-1:0] dataIn = '0;
  logic [W-1:0] auxIn = '0;
  logic         startReq = 1'b0;
  logic         realign = 1'b0;
  logic         slipAux, locked, alignErr, dataWe, auxWe;
  logic [W-1:0] dataOut, auxOut;

  int  nChecks = 0;
  int  nFails = 0;
  int  cyc = 0;
  int  aOff = DOFF;
  int  slipsSeen = 0;
  bit  countMode = 1'b0;
  bit  forceOn = 1'b0;
  logic [W-1:0] forceData = '0;
  logic [W-1:0] forceAux = '0;

  always #4 clk = ~clk;

  lane_pair_aligner uut (
    .clk(clk), .rstN(rstN), .dataIn(dataIn), .auxIn(auxIn),
    .startReq(startReq), .realign(realign), .slipAux(slipAux),
    .locked(locked), .alignErr(alignErr), .dataOut(dataOut),
    .auxOut(auxOut), .dataWe(dataWe), .auxWe(auxWe)
  );

  function automatic logic [W-1:0] streamWord(int j, bit aux);
    logic [W-1:0] v;
    if (countMode) begin
      v = W'(j);
      if (aux) v = ~v;
    end else begin
      v = (j % 2 == 1) ? ~PAT : PAT;
    end
    return v;
  endfunction

  function automatic logic [W-1:0] laneWord(int base, bit aux);
    logic [W-1:0] r;
    logic [W-1:0] w;
    for (int k = 0; k < W; k++) begin
      w = streamWord((base + k) / W, aux);
      r[W-1-k] = w[W-1-((base + k) % W)];
    end
    return r;
  endfunction

  // deserializer pair model: advances at the falling edge
  initial begin
    forever begin
      @(negedge clk);
      if (rstN && slipAux) begin
        slipsSeen++;
        aOff++;
      end
      cyc++;
      dataIn = forceOn ? forceData : laneWord(W * cyc + DOFF, 1'b0);
      auxIn  = forceOn ? forceAux  : laneWord(W * cyc + aOff, 1'b1);
    end
  end

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic check(bit ok, string req, int act, int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic doRealign();
    realign = 1'b1;
    tick();
    realign = 1'b0;
    check(!locked && !dataWe && !auxWe && !alignErr, "R8", {locked, dataWe, alignErr}, 0);
  endtask

  task automatic waitSettled(output bit gotLock);
    gotLock = 1'b0;
    for (int n = 0; n < 2000; n++) begin
      tick();
      if (locked || alignErr) begin
        gotLock = locked;
        break;
      end
    end
  endtask

  task automatic runCase(int s, bit viaRealign);
    bit got;
    bit early;
    bit weBad;
    logic [W-1:0] prev;
    early = (s % 2 == 1);
    weBad = 1'b0;
    countMode = 1'b0;
    startReq = 1'b0;
    if (viaRealign) begin
      aOff = DOFF - s;
      slipsSeen = 0;
      doRealign();
    end
    if (early) begin
      for (int n = 0; n < 4; n++) tick();
      startReq = 1'b1;
    end
    got = 1'b0;
    for (int n = 0; n < 2000; n++) begin
      tick();
      if (locked || alignErr) begin
        got = locked;
        break;
      end
      if (dataWe || auxWe) weBad = 1'b1;
    end
    check(got && !alignErr, "R4", int'(locked), 1);
    check(slipsSeen == s, "R3", slipsSeen, s);
    countMode = 1'b1;
    if (early) begin
      check(!weBad && !dataWe, "R9", int'(dataWe), 0);
      tick();
      check(dataWe && auxWe, "R9", int'(dataWe), 1);
    end else begin
      for (int n = 0; n < 6; n++) tick();
      check(!dataWe && !auxWe, "R6", int'(dataWe), 0);
      startReq = 1'b1;
      tick(); tick(); tick();
      check(!dataWe, "R6", int'(dataWe), 0);
      tick();
      check(dataWe && auxWe, "R6", int'(dataWe), 1);
    end
    tick(); tick(); tick();
    prev = dataOut;
    for (int n = 0; n < 4; n++) begin
      tick();
      check(dataWe && (auxOut == ~dataOut), "R7", int'(auxOut), int'(~dataOut));
      check(dataOut == prev + 1'b1, "R7", int'(dataOut), int'(W'(prev + 1'b1)));
      prev = dataOut;
    end
    check(locked, "R4", int'(locked), 1);
    startReq = 1'b0;
  endtask

  task automatic errCase(logic [W-1:0] dv, logic [W-1:0] av, string req);
    bit got;
    int held;
    startReq = 1'b0;
    forceData = dv;
    forceAux = av;
    forceOn = 1'b1;
    slipsSeen = 0;
    doRealign();
    waitSettled(got);
    check(!got && alignErr, req, int'(alignErr), 1);
    check(slipsSeen == BUDGET, "R5", slipsSeen, BUDGET);
    held = slipsSeen;
    for (int n = 0; n < 60; n++) tick();
    check(slipsSeen == held && alignErr && !locked, "R5", slipsSeen, held);
    forceOn = 1'b0;
    countMode = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    nFails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    aOff = DOFF;
    for (int n = 0; n < 4; n++) tick();
    check(!locked && !alignErr && !slipAux && !dataWe && !auxWe, "R1",
          {locked, alignErr, slipAux, dataWe, auxWe}, 0);
    rstN = 1'b1;
    runCase(0, 1'b0);
    for (int s = 1; s < 16; s++) runCase(s, 1'b1);
    runCase(0, 1'b1);
    // equal lanes but not a pattern word never lock
    errCase(8'h3C, 8'h3C, "R2");
    // auxiliary lane never matches: budget exhausted
    errCase(PAT, 8'h00, "R5");
    // recovery after an error
    runCase(7, 1'b1);
    runCase(10, 1'b1);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule